// File: doc/BRIEF.md
# IEC 60958 Subframe Packer

This block sits in a digital audio transmit path and turns a stream of interleaved audio samples into 32-bit transmit words ready for a later line coder. It has two modes. In PCM mode each 24-bit sample is placed in the low bits of the word. The block then adds the channel-status bit for the current frame, an even-parity bit and a flag that marks the start of a 192-frame status block. The channel-status bits come from four configuration bytes. The channel-number field of the third byte is rewritten for each channel.

In passthrough mode the block expects words that upstream logic has already formatted. These words carry their flag bits on top and a preamble code at the bottom, and the block shifts them into the transmit layout. Both sides of the block use valid/ready handshakes, and a single output register stage holds one word. A restart pulse moves the position back to the start of a block. The mode, the channel count and the status bytes are captured only while the block rests at the block origin, so a running block never sees a configuration change in its middle.

Top module: `sfp_subframe_packer`

## Requirements
- R1: In PCM mode an output word carries the input sample bits 23:0 in bits 23:0, the channel-status bit in bit 26, parity in bit 27 and the block-start flag in bit 28. Bits 25:24 and 31:29 are zero, and input bits 31:24 are ignored.
- R2: In PCM mode, bits 27:0 of every output word hold an even number of ones. The parity bit is the XOR of bits 26:0.
- R3: The status bit of frame n (n below 32) is bit n mod 8 of status byte n div 8, counted from the least significant bit. Frames 32 to 191 carry a zero status bit.
- R4: For channel index c, bits 7:4 of status byte 2 are replaced by c+1. Bits 3:0 of that byte come from the configuration.
- R5: The block-start flag is 1 only on channel 0 of frame 0.
- R6: Samples are taken as channel 0 to N-1 of one frame, and all of them share that frame's index. The frame index counts 0 to 191 and then wraps to 0. A channel count below 2 acts as 2, and one above 8 acts as 8.
- R7: In passthrough mode, output bits 27:0 equal input bits 31:4, output bit 28 equals input bit 3, and output bits 31:29 are zero.
- R8: The mode, the channel count and the four status bytes are captured in every cycle in which the position is frame 0, channel 0 and no sample is accepted. At any other time, changes on those inputs have no effect.
- R9: A restart pulse returns the position to frame 0, channel 0. A sample accepted in the same cycle is formatted with the position held before the restart.
- R10: in_ready is high exactly when the output register is empty or out_ready is high. A stalled output word stays stable, and no accepted sample is lost or reordered.
- R11: After reset out_valid is 0, in_ready is 1 and the position is frame 0, channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Pulse that returns the position to frame 0, channel 0 |
| pass_mode | input | 1 | 1 selects passthrough, 0 selects PCM (captured at origin) |
| chan_count | input | 4 | Channels per frame, 2 to 8 (captured at origin) |
| cs_byte0 | input | 8 | Status byte 0 |
| cs_byte1 | input | 8 | Status byte 1 |
| cs_byte2 | input | 8 | Status byte 2; bits 7:4 are replaced per channel |
| cs_byte3 | input | 8 | Status byte 3 |
| in_valid | input | 1 | Input sample valid |
| in_data | input | 32 | Input sample or preformatted word |
| in_ready | output | 1 | Block can take a sample |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Transmit word |
| out_ready | input | 1 | Downstream takes the word |

## Verification
Two events can fall in the same cycle here: a restart pulse and an accepted sample. The bench drives restart together with a sample in the middle of a block. It then requires that word to keep its old frame and channel position, and requires the next word to be channel 0 of frame 0 with the block-start flag set. A second overlap comes from configuration changes. The bench changes the status bytes while a block is running and confirms that the words up to frame 31 still carry the old bits. The new bytes must appear only after the next return to the origin.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned CS_BYTES = 4;
  localparam int unsigned BIT_CS   = 26;
  localparam int unsigned BIT_PAR  = 27;
  localparam int unsigned BIT_BLK  = 28;

  typedef struct packed {
    logic       pass;
    logic [7:0] b3;
    logic [7:0] b2;
    logic [7:0] b1;
    logic [7:0] b0;
  } sfp_cfg_t;
endpackage

// File: rtl/sfp_position_ctr.sv
module sfp_position_ctr #(
  parameter int unsigned CH_MAX = 8,
  parameter int unsigned FRAMES = 192,
  localparam int unsigned CH_W  = $clog2(CH_MAX),
  localparam int unsigned CNT_W = $clog2(CH_MAX + 1),
  localparam int unsigned FR_W  = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic [CNT_W-1:0] nch,
  output logic [FR_W-1:0]  frame,
  output logic [CH_W-1:0]  chan,
  output logic             at_origin
);
  logic [FR_W-1:0] frame_d;
  logic [CH_W-1:0] chan_d;
  logic            chan_last;
  logic            pos_en;

  assign chan_last = ((CNT_W'(chan) + CNT_W'(1)) == nch);
  assign at_origin = (frame == '0) && (chan == '0);
  assign pos_en    = restart | advance;

  always_comb begin
    frame_d = frame;
    chan_d  = chan;
    if (restart) begin
      frame_d = '0;
      chan_d  = '0;
    end else if (advance) begin
      if (chan_last) begin
        chan_d  = '0;
        frame_d = (frame == FR_W'(FRAMES - 1)) ? '0 : frame + FR_W'(1);
      end else begin
        chan_d = chan + CH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '0;
      chan  <= '0;
    end else if (pos_en) begin
      frame <= frame_d;
      chan  <= chan_d;
    end
  end

  a_r9_restart_origin: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (frame == '0) && (chan == '0));
  a_r6_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
    frame < FR_W'(FRAMES));
  a_r6_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && chan_last && frame == FR_W'(FRAMES - 1)) |=> (frame == '0));
  a_r6_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(chan) < nch);
endmodule

// File: rtl/sfp_cfg_hold.sv
module sfp_cfg_hold
  import sfp_pkg::*;
#(
  parameter int unsigned CH_MAX = 8,
  localparam int unsigned CNT_W = $clog2(CH_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  sfp_cfg_t         cfg_i,
  input  logic [CNT_W-1:0] nch_i,
  output sfp_cfg_t         cfg_q,
  output logic [CNT_W-1:0] nch_q
);
  logic [CNT_W-1:0] nch_clamped;

  always_comb begin
    if (nch_i < CNT_W'(2))
      nch_clamped = CNT_W'(2);
    else if (nch_i > CNT_W'(CH_MAX))
      nch_clamped = CNT_W'(CH_MAX);
    else
      nch_clamped = nch_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      nch_q <= CNT_W'(2);
    end else if (load) begin
      cfg_q <= cfg_i;
      nch_q <= nch_clamped;
    end
  end

  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(cfg_q) && $stable(nch_q)));
  a_r6_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (nch_q >= CNT_W'(2)) && (nch_q <= CNT_W'(CH_MAX)));
endmodule

// File: rtl/sfp_pcm_fmt.sv
module sfp_pcm_fmt
  import sfp_pkg::*;
#(
  parameter int unsigned CH_MAX = 8,
  parameter int unsigned FRAMES = 192,
  localparam int unsigned CH_W  = $clog2(CH_MAX),
  localparam int unsigned FR_W  = $clog2(FRAMES),
  localparam int unsigned CS_W  = 8 * CS_BYTES
) (
  input  logic [WORD_W-1:0] sample,
  input  logic [FR_W-1:0]   frame,
  input  logic [CH_W-1:0]   chan,
  input  logic              origin,
  input  sfp_cfg_t          cfg,
  output logic [WORD_W-1:0] word
);
  logic [7:0]      cs_byte [CS_BYTES];
  logic [CS_W-1:0] cs_vec;
  logic            cs_bit;
  logic [3:0]      chan_num;

  assign chan_num   = 4'(chan) + 4'd1;
  assign cs_byte[0] = cfg.b0;
  assign cs_byte[1] = cfg.b1;
  assign cs_byte[2] = {chan_num, cfg.b2[3:0]};
  assign cs_byte[3] = cfg.b3;

  for (genvar i = 0; i < CS_BYTES; i++) begin : g_csv
    assign cs_vec[8*i +: 8] = cs_byte[i];
  end

  assign cs_bit = (frame < FR_W'(CS_W)) ? cs_vec[frame[$clog2(CS_W)-1:0]] : 1'b0;

  always_comb begin
    word                    = '0;
    word[SAMPLE_W-1:0]      = sample[SAMPLE_W-1:0];
    word[BIT_CS]            = cs_bit;
    word[BIT_BLK]           = origin;
    word[BIT_PAR]           = ^word[BIT_CS:0];
  end
endmodule

// File: rtl/sfp_pass_fmt.sv
module sfp_pass_fmt
  import sfp_pkg::*;
(
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word              = '0;
    word[BIT_BLK-1:0] = din[WORD_W-1:4];
    word[BIT_BLK]     = din[3];
  end
endmodule

// File: rtl/sfp_subframe_packer.sv
module sfp_subframe_packer
  import sfp_pkg::*;
#(
  parameter int unsigned CH_MAX = 8,
  parameter int unsigned FRAMES = 192,
  localparam int unsigned CH_W  = $clog2(CH_MAX),
  localparam int unsigned CNT_W = $clog2(CH_MAX + 1),
  localparam int unsigned FR_W  = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              pass_mode,
  input  logic [CNT_W-1:0]  chan_count,
  input  logic [7:0]        cs_byte0,
  input  logic [7:0]        cs_byte1,
  input  logic [7:0]        cs_byte2,
  input  logic [7:0]        cs_byte3,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_ready
);
  sfp_cfg_t          cfg_in, cfg_q;
  logic [CNT_W-1:0]  nch_q;
  logic [FR_W-1:0]   frame;
  logic [CH_W-1:0]   chan;
  logic              at_origin;
  logic              accept;
  logic              cfg_load;
  logic [WORD_W-1:0] pcm_word, pass_word, fmt_word;
  logic              out_valid_d;
  logic              out_pcm;

  assign cfg_in   = '{pass: pass_mode, b3: cs_byte3, b2: cs_byte2, b1: cs_byte1, b0: cs_byte0};
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign cfg_load = at_origin && !accept;

  sfp_cfg_hold #(.CH_MAX(CH_MAX)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .cfg_i(cfg_in), .nch_i(chan_count), .cfg_q(cfg_q), .nch_q(nch_q)
  );

  sfp_position_ctr #(.CH_MAX(CH_MAX), .FRAMES(FRAMES)) u_pos (
    .clk(clk), .rst_n(rst_n), .restart(restart), .advance(accept),
    .nch(nch_q), .frame(frame), .chan(chan), .at_origin(at_origin)
  );

  sfp_pcm_fmt #(.CH_MAX(CH_MAX), .FRAMES(FRAMES)) u_pcm (
    .sample(in_data), .frame(frame), .chan(chan), .origin(at_origin),
    .cfg(cfg_q), .word(pcm_word)
  );

  sfp_pass_fmt u_pass (.din(in_data), .word(pass_word));

  assign fmt_word = cfg_q.pass ? pass_word : pcm_word;

  always_comb begin
    if (accept)
      out_valid_d = 1'b1;
    else if (out_ready)
      out_valid_d = 1'b0;
    else
      out_valid_d = out_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_valid <= 1'b0;
    else
      out_valid <= out_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_pcm  <= 1'b0;
    end else if (accept) begin
      out_data <= fmt_word;
      out_pcm  <= !cfg_q.pass;
    end
  end

  a_r2_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pcm) |-> (^out_data[BIT_PAR:0] == 1'b0));
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r5_start_only_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cfg_q.pass && !at_origin) |=> !out_data[BIT_BLK]);
  a_r1_pcm_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pcm) |-> (out_data[31:29] == 3'b0 && out_data[25:24] == 2'b0));
endmodule

// File: tb/sim_sfp_subframe_packer.sv
module sim_sfp_subframe_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic        pass_mode = 1'b0;
  logic [3:0]  chan_count = 4'd2;
  logic [7:0]  cs_byte0 = '0, cs_byte1 = '0, cs_byte2 = '0, cs_byte3 = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready = 1'b1;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [31:0] rx [0:2047];
  logic [31:0] ex [0:2047];
  int rx_n = 0;
  int ex_n = 0;

  int m_f = 0, m_c = 0, m_cnt = 2;
  logic m_pass = 1'b0;
  logic [7:0] m_b0 = '0, m_b1 = '0, m_b2 = '0, m_b3 = '0;
  int seed = 1;

  always #2 clk = ~clk;

  sfp_subframe_packer u0 (
    .clk(clk), .rst_n(rst_n), .restart(restart), .pass_mode(pass_mode),
    .chan_count(chan_count), .cs_byte0(cs_byte0), .cs_byte1(cs_byte1),
    .cs_byte2(cs_byte2), .cs_byte3(cs_byte3), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready)
  );

  always begin
    @(negedge clk);
    #1;
    if (rst_n && out_valid && out_ready && rx_n < 2048) begin
      rx[rx_n] = out_data;
      rx_n++;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] d, input int f, input int c);
    logic [31:0] w, cs;
    w = '0;
    if (m_pass) begin
      w[27:0] = d[31:4];
      w[28]   = d[3];
    end else begin
      cs      = {m_b3, 4'(c + 1), m_b2[3:0], m_b1, m_b0};
      w[23:0] = d[23:0];
      w[26]   = (f < 32) ? cs[f] : 1'b0;
      w[28]   = (f == 0 && c == 0);
      w[27]   = ^w[26:0];
    end
    return w;
  endfunction

  function automatic logic [31:0] next_sample();
    seed = seed * 1103515245 + 12345;
    return 32'(seed) ^ 32'hA5000000;
  endfunction

  task automatic clear_q();
    rx_n = 0;
    ex_n = 0;
  endtask

  task automatic push(input logic [31:0] d, input bit rs);
    ex[ex_n] = exp_word(d, m_f, m_c);
    ex_n++;
    if (rs) begin
      m_f = 0;
      m_c = 0;
    end else begin
      m_c++;
      if (m_c == m_cnt) begin
        m_c = 0;
        m_f = (m_f + 1) % 192;
      end
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    restart  = rs;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    restart  = 1'b0;
  endtask

  task automatic drain_and_compare(input string req);
    repeat (4) @(negedge clk);
    chk(rx_n == ex_n, req, 32'(rx_n), 32'(ex_n));
    for (int i = 0; i < ex_n && i < rx_n; i++)
      chk(rx[i] === ex[i], req, rx[i], ex[i]);
  endtask

  task automatic set_cfg(input bit p, input logic [3:0] n, input logic [7:0] b0,
                         input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3);
    @(negedge clk);
    pass_mode = p; chan_count = n;
    cs_byte0 = b0; cs_byte1 = b1; cs_byte2 = b2; cs_byte3 = b3;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    repeat (2) @(negedge clk);
    m_pass = p;
    m_cnt = (n < 2) ? 2 : (n > 8) ? 8 : int'(n);
    m_b0 = b0; m_b1 = b1; m_b2 = b2; m_b3 = b3;
    m_f = 0; m_c = 0;
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid == 1'b0, "R11 out_valid after reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R11 in_ready after reset", 32'(in_ready), 32'd1);
  endtask

  task automatic t_stereo_blocks();
    set_cfg(1'b0, 4'd2, 8'h2D, 8'h81, 8'h0B, 8'hC6);
    clear_q();
    for (int i = 0; i < 2 * 192 * 2; i++) push(next_sample(), 1'b0);
    drain_and_compare("R1 R3 R5 R6 stereo two blocks");
    for (int i = 0; i < rx_n; i++)
      chk(^rx[i][27:0] == 1'b0, "R2 even parity", {31'b0, ^rx[i][27:0]}, 32'd0);
    chk(rx[384][28] == 1'b1, "R5 R6 start after wrap", 32'(rx[384][28]), 32'd1);
  endtask

  task automatic t_eight_channels();
    set_cfg(1'b0, 4'd8, 8'hF0, 8'h0F, 8'h05, 8'h3C);
    clear_q();
    for (int i = 0; i < 40 * 8; i++) push(next_sample(), 1'b0);
    drain_and_compare("R4 R6 eight channels");
    for (int c = 0; c < 8; c++)
      chk(rx[20 * 8 + c][26] == ((4'(c + 1) >> 0) & 4'd1),
          "R4 channel number bit 4 in frame 20", 32'(rx[160 + c][26]), 32'((c + 1) & 1));
  endtask

  task automatic t_clamp();
    set_cfg(1'b0, 4'd1, 8'h00, 8'h00, 8'h00, 8'h00);
    clear_q();
    for (int i = 0; i < 40 * 2; i++) push(next_sample(), 1'b0);
    drain_and_compare("R6 count below two clamps");
    set_cfg(1'b0, 4'd11, 8'h00, 8'h00, 8'h00, 8'h00);
    clear_q();
    for (int i = 0; i < 24 * 8; i++) push(next_sample(), 1'b0);
    drain_and_compare("R6 count above eight clamps");
  endtask

  task automatic t_cfg_ignore();
    set_cfg(1'b0, 4'd2, 8'hAA, 8'h55, 8'h03, 8'h99);
    clear_q();
    for (int i = 0; i < 5; i++) push(next_sample(), 1'b0);
    @(negedge clk);
    cs_byte0 = 8'h11; cs_byte1 = 8'hEE; cs_byte2 = 8'h0C; cs_byte3 = 8'h42;
    pass_mode = 1'b1; chan_count = 4'd6;
    for (int i = 0; i < 64; i++) push(next_sample(), 1'b0);
    drain_and_compare("R8 mid-block config change ignored");
    set_cfg(1'b0, 4'd6, 8'h11, 8'hEE, 8'h0C, 8'h42);
    clear_q();
    for (int i = 0; i < 32 * 6; i++) push(next_sample(), 1'b0);
    drain_and_compare("R8 new config at origin");
  endtask

  task automatic t_restart_overlap();
    set_cfg(1'b0, 4'd2, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    clear_q();
    for (int i = 0; i < 7; i++) push(next_sample(), 1'b0);
    push(next_sample(), 1'b1);
    push(next_sample(), 1'b0);
    push(next_sample(), 1'b0);
    drain_and_compare("R9 restart with accepted sample");
    chk(rx[7][28] == 1'b0, "R9 restart word keeps old position", 32'(rx[7][28]), 32'd0);
    chk(rx[8][28] == 1'b1, "R9 word after restart is block start", 32'(rx[8][28]), 32'd1);
  endtask

  task automatic t_passthrough();
    set_cfg(1'b1, 4'd2, 8'h00, 8'h00, 8'h00, 8'h00);
    clear_q();
    push(32'hF1234568, 1'b0);
    push(32'h0ABCDEF4, 1'b0);
    push(32'h80000002, 1'b0);
    for (int i = 0; i < 20; i++) push(next_sample(), 1'b0);
    drain_and_compare("R7 passthrough mapping");
    chk(rx[0] === 32'h1F123456, "R7 block start from bit 3", rx[0], 32'h1F123456);
    chk(rx[1] === 32'h00ABCDEF, "R7 even preamble", rx[1], 32'h00ABCDEF);
  endtask

  task automatic t_backpressure();
    logic [31:0] prev_data;
    bit prev_stall;
    set_cfg(1'b0, 4'd3, 8'h5A, 8'hA5, 8'h07, 8'h18);
    clear_q();
    prev_stall = 1'b0;
    prev_data  = '0;
    fork
      begin
        for (int i = 0; i < 150; i++) push(next_sample(), 1'b0);
      end
      begin
        for (int k = 0; k < 700; k++) begin
          @(negedge clk);
          out_ready = ((k % 5) == 1) || ((k % 7) == 3);
          #1;
          chk(in_ready == (!out_valid || out_ready), "R10 in_ready rule",
              32'(in_ready), 32'(!out_valid || out_ready));
          if (prev_stall)
            chk(out_valid && out_data === prev_data, "R10 stalled word stable", out_data, prev_data);
          prev_stall = out_valid && !out_ready;
          prev_data  = out_data;
        end
        out_ready = 1'b1;
      end
    join
    drain_and_compare("R10 no loss under backpressure");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_stereo_blocks();
    t_eight_channels();
    t_clamp();
    t_cfg_ignore();
    t_restart_overlap();
    t_passthrough();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule